// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block converts a segment-relative memory access into a byte address in a 64 KiB physical memory. The requester names one of three segments (code, data or stack) and an offset. The block adds the offset to that segment's base to form a 16-bit linear address, checking the offset against the segment's limit on the way. The upper nine bits of the linear address then select an entry in a 512-entry page table. Pages are 128 bytes. Each entry holds a 9-bit frame number and a valid flag. The physical address is the frame number followed by the low seven bits of the linear address.

Stack accesses carry a direction. A push uses the current stack counter as its offset. A pop uses the counter minus one. Running past the top of the stack or below its bottom raises a dedicated trap cause. Any other failure also raises the trap with a 2-bit cause. This covers an offset past a limit, a base-plus-offset sum beyond 16 bits, an unused segment select, and a page-table entry that is not valid. The result is registered and appears one cycle after the request strobe. Software loads the page table through a simple write port, one entry per cycle.

Top module: `segpage_xlate`

## Requirements
- R1: While reset is asserted, and until the first request after it, `rsp_valid` and `rsp_trap` are low.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. It is low otherwise.
- R3: For segment select 0 (code) or 1 (data), an offset greater than or equal to that segment's limit gives a trap with cause 0 (bounds).
- R4: The linear address is the selected base plus the effective offset. If that sum carries out of 16 bits, the access traps with cause 0.
- R5: For segment select 2 (stack) with `req_push` high, the effective offset is the counter given on `req_offset`. A counter greater than or equal to `stack_limit` traps with cause 1 (overflow).
- R6: For a stack access with `req_push` low, a counter of 0 traps with cause 2 (underflow). A counter greater than `stack_limit` traps with cause 1. Otherwise the effective offset is the counter minus one.
- R7: If the page-table entry for linear bits [15:7] is not valid, the access traps with cause 3 (no page). All entries are invalid after reset.
- R8: A non-trapping response gives `rsp_paddr` = {frame, linear[6:0]}, with `rsp_cause` equal to 0.
- R9: Segment checks take priority over the page check. On any trap, `rsp_paddr` is 0.
- R10: A write with `pt_we` high stores `pt_frame` and `pt_valid` into entry `pt_index`. The write affects requests from the next cycle on. A request in the same cycle sees the old entry.
- R11: Segment select 3 always traps with cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_base | input | 16 | Code segment base |
| code_limit | input | 16 | Code segment size in bytes |
| data_base | input | 16 | Data segment base |
| data_limit | input | 16 | Data segment size in bytes |
| stack_base | input | 16 | Stack segment base |
| stack_limit | input | 16 | Stack size in bytes |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 2 | Segment select: 0 code, 1 data, 2 stack, 3 unused |
| req_push | input | 1 | Stack direction: 1 push, 0 pop |
| req_offset | input | 16 | Offset, or stack counter for stack accesses |
| pt_we | input | 1 | Page-table write enable |
| pt_index | input | 9 | Page-table entry to write |
| pt_frame | input | 9 | Frame number to store |
| pt_valid | input | 1 | Valid flag to store |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_trap | output | 1 | Access violation |
| rsp_cause | output | 2 | 0 bounds, 1 stack overflow, 2 stack underflow, 3 no page |
| rsp_paddr | output | 16 | Physical byte address |

## Verification
The only state in the block is the page table and the response register. A corrupted frame or valid bit therefore shows up on the very next response that touches that page: either a wrong high part of `rsp_paddr` or a spurious cause-3 trap. A wrong response register shows up as a misplaced or missing `rsp_valid` one cycle after the strobe. The directed tests map a few pages and hit every cause at both edges of each limit. They also remap and unmap pages, including a write in the same cycle as a request. Because of this, a stale or misindexed entry is seen at the ports within one request.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_NONE  = 2'd3
  } seg_t;

  typedef enum logic [1:0] {
    CAUSE_BOUNDS    = 2'd0,
    CAUSE_STK_OVER  = 2'd1,
    CAUSE_STK_UNDER = 2'd2,
    CAUSE_NO_PAGE   = 2'd3
  } cause_t;

endpackage

// File: rtl/segpage_segchk.sv
module segpage_segchk
  import segpage_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [1:0]        sel,
  input  logic              push,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] code_base,
  input  logic [ADDR_W-1:0] code_limit,
  input  logic [ADDR_W-1:0] data_base,
  input  logic [ADDR_W-1:0] data_limit,
  input  logic [ADDR_W-1:0] stack_base,
  input  logic [ADDR_W-1:0] stack_limit,
  output logic [ADDR_W-1:0] linear,
  output logic              fault,
  output cause_t            cause
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] eff;
  logic [ADDR_W:0]   sum;

  always_comb begin
    fault = 1'b0;
    cause = CAUSE_BOUNDS;
    base  = '0;
    eff   = offset;
    case (sel)
      SEG_CODE: begin
        base  = code_base;
        fault = (offset >= code_limit);
      end
      SEG_DATA: begin
        base  = data_base;
        fault = (offset >= data_limit);
      end
      SEG_STACK: begin
        base = stack_base;
        if (push) begin
          if (offset >= stack_limit) begin
            fault = 1'b1;
            cause = CAUSE_STK_OVER;
          end
        end else if (offset == '0) begin
          fault = 1'b1;
          cause = CAUSE_STK_UNDER;
        end else begin
          eff = offset - ADDR_W'(1);
          if (offset > stack_limit) begin
            fault = 1'b1;
            cause = CAUSE_STK_OVER;
          end
        end
      end
      default: fault = 1'b1;
    endcase
    sum = {1'b0, base} + {1'b0, eff};
    if (!fault && sum[ADDR_W]) fault = 1'b1;
    linear = sum[ADDR_W-1:0];
  end

endmodule

// File: rtl/segpage_ptable.sv
module segpage_ptable #(
  parameter int IDX_W   = 9,
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_valid,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_valid
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [FRAME_W-1:0] frame_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) frame_mem[wr_idx] <= wr_frame;
  end

  assign rd_frame = frame_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] code_base,
  input  logic [ADDR_W-1:0] code_limit,
  input  logic [ADDR_W-1:0] data_base,
  input  logic [ADDR_W-1:0] data_limit,
  input  logic [ADDR_W-1:0] stack_base,
  input  logic [ADDR_W-1:0] stack_limit,
  input  logic              req_valid,
  input  logic [1:0]        req_seg,
  input  logic              req_push,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic              pt_we,
  input  logic [ADDR_W-OFF_W-1:0] pt_index,
  input  logic [ADDR_W-OFF_W-1:0] pt_frame,
  input  logic              pt_valid,
  output logic              rsp_valid,
  output logic              rsp_trap,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr
);

  localparam int PN_W = ADDR_W - OFF_W;

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [ADDR_W-1:0] linear;
  logic              seg_fault;
  cause_t            seg_cause;
  logic [PN_W-1:0]   map_frame;
  logic              map_valid;

  segpage_segchk #(.ADDR_W(ADDR_W)) u_segchk (
    .sel         (req_seg),
    .push        (req_push),
    .offset      (req_offset),
    .code_base   (code_base),
    .code_limit  (code_limit),
    .data_base   (data_base),
    .data_limit  (data_limit),
    .stack_base  (stack_base),
    .stack_limit (stack_limit),
    .linear      (linear),
    .fault       (seg_fault),
    .cause       (seg_cause)
  );

  segpage_ptable #(.IDX_W(PN_W), .FRAME_W(PN_W)) u_ptable (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (pt_we),
    .wr_idx   (pt_index),
    .wr_frame (pt_frame),
    .wr_valid (pt_valid),
    .rd_idx   (linear[ADDR_W-1:OFF_W]),
    .rd_frame (map_frame),
    .rd_valid (map_valid)
  );

  logic              valid_d, trap_d;
  logic [1:0]        cause_d;
  logic [ADDR_W-1:0] paddr_d;

  always_comb begin
    valid_d = req_valid;
    trap_d  = 1'b0;
    cause_d = CAUSE_BOUNDS;
    paddr_d = '0;
    if (seg_fault) begin
      trap_d  = req_valid;
      cause_d = seg_cause;
    end else if (!map_valid) begin
      trap_d  = req_valid;
      cause_d = CAUSE_NO_PAGE;
    end else begin
      paddr_d = {map_frame, linear[OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_cause <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_trap  <= trap_d;
      if (req_valid) begin
        rsp_cause <= cause_d;
        rsp_paddr <= paddr_d;
      end
    end
  end

endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk
  import segpage_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_seg,
  input logic              req_push,
  input logic [ADDR_W-1:0] req_offset,
  input logic [ADDR_W-1:0] data_limit,
  input logic [ADDR_W-1:0] stack_limit,
  input logic              rsp_valid,
  input logic              rsp_trap,
  input logic [1:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_paddr
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2

  AST_TRAP_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_valid && rsp_paddr == '0)); // R9

  AST_DATA_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seg == SEG_DATA && req_offset >= data_limit)
      |=> (rsp_trap && rsp_cause == CAUSE_BOUNDS)); // R3

  AST_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seg == SEG_STACK && req_push && req_offset >= stack_limit)
      |=> (rsp_trap && rsp_cause == CAUSE_STK_OVER)); // R5

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seg == SEG_STACK && !req_push && req_offset == '0)
      |=> (rsp_trap && rsp_cause == CAUSE_STK_UNDER)); // R6

  AST_SEG_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seg == SEG_NONE)
      |=> (rsp_trap && rsp_cause == CAUSE_BOUNDS)); // R11

endmodule

bind segpage_xlate segpage_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .req_valid   (req_valid),
  .req_seg     (req_seg),
  .req_push    (req_push),
  .req_offset  (req_offset),
  .data_limit  (data_limit),
  .stack_limit (stack_limit),
  .rsp_valid   (rsp_valid),
  .rsp_trap    (rsp_trap),
  .rsp_cause   (rsp_cause),
  .rsp_paddr   (rsp_paddr)
);

// File: tb/segpage_xlate_bench.sv
module segpage_xlate_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] code_base, code_limit, data_base, data_limit, stack_base, stack_limit;
  logic        req_valid;
  logic [1:0]  req_seg;
  logic        req_push;
  logic [15:0] req_offset;
  logic        pt_we;
  logic [8:0]  pt_index, pt_frame;
  logic        pt_valid;
  logic        rsp_valid, rsp_trap;
  logic [1:0]  rsp_cause;
  logic [15:0] rsp_paddr;

  int checks = 0;
  int errors = 0;

  segpage_xlate u_segpage_xlate (
    .clk(clk), .rst_n(rst_n),
    .code_base(code_base), .code_limit(code_limit),
    .data_base(data_base), .data_limit(data_limit),
    .stack_base(stack_base), .stack_limit(stack_limit),
    .req_valid(req_valid), .req_seg(req_seg), .req_push(req_push),
    .req_offset(req_offset),
    .pt_we(pt_we), .pt_index(pt_index), .pt_frame(pt_frame), .pt_valid(pt_valid),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive a request, sample the registered response one cycle later
  task automatic access(input logic [1:0] seg, input logic push, input logic [15:0] off,
                        input string tag, input logic trap, input logic [1:0] cause,
                        input logic [15:0] paddr);
    @(negedge clk);
    req_valid = 1'b1; req_seg = seg; req_push = push; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {11'd0, rsp_valid, rsp_trap, rsp_cause, rsp_paddr},
               {11'd0, 1'b1, trap, trap ? cause : 2'd0, trap ? 16'd0 : paddr});
  endtask

  task automatic map_page(input logic [8:0] idx, input logic [8:0] frm, input logic v);
    @(negedge clk);
    pt_we = 1'b1; pt_index = idx; pt_frame = frm; pt_valid = v;
    @(negedge clk);
    pt_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 during reset", {30'd0, rsp_valid, rsp_trap}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {30'd0, rsp_valid, rsp_trap}, 32'd0);
  endtask

  task automatic t_unmapped;
    // nothing mapped yet: valid code access hits an invalid entry
    access(2'd0, 1'b0, 16'h0010, "R7 empty table", 1'b1, 2'd3, 16'h0);
    map_page(9'h020, 9'h005, 1'b1);
    map_page(9'h040, 9'h1A3, 1'b1);
    map_page(9'h060, 9'h0FF, 1'b1);
  endtask

  task automatic t_code_data;
    access(2'd0, 1'b0, 16'h0010, "R8 code hit", 1'b0, 2'd0, 16'h0290);
    access(2'd0, 1'b0, 16'h0100, "R3 code at limit", 1'b1, 2'd0, 16'h0);
    access(2'd0, 1'b0, 16'h00FF, "R7 code next page", 1'b1, 2'd3, 16'h0);
    access(2'd1, 1'b0, 16'h003F, "R8 data last byte", 1'b0, 2'd0, 16'hD1BF);
    access(2'd1, 1'b0, 16'h0040, "R3 data at limit", 1'b1, 2'd0, 16'h0);
    access(2'd0, 1'b0, 16'h01F0, "R9 bounds beats no page", 1'b1, 2'd0, 16'h0);
  endtask

  task automatic t_carry;
    data_base = 16'hFFF0;
    access(2'd1, 1'b0, 16'h0020, "R4 sum carry", 1'b1, 2'd0, 16'h0);
    data_base = 16'h2000;
  endtask

  task automatic t_stack;
    access(2'd2, 1'b1, 16'd0,  "R5 push empty", 1'b0, 2'd0, 16'h7F80);
    access(2'd2, 1'b1, 16'd49, "R5 push last slot", 1'b0, 2'd0, 16'h7FB1);
    access(2'd2, 1'b1, 16'd50, "R5 push full", 1'b1, 2'd1, 16'h0);
    access(2'd2, 1'b0, 16'd0,  "R6 pop empty", 1'b1, 2'd2, 16'h0);
    access(2'd2, 1'b0, 16'd50, "R6 pop top", 1'b0, 2'd0, 16'h7FB1);
    access(2'd2, 1'b0, 16'd1,  "R6 pop bottom", 1'b0, 2'd0, 16'h7F80);
    access(2'd2, 1'b0, 16'd51, "R6 pop past limit", 1'b1, 2'd1, 16'h0);
  endtask

  task automatic t_select;
    access(2'd3, 1'b0, 16'h0000, "R11 unused select", 1'b1, 2'd0, 16'h0);
    @(negedge clk);
    check("R2 idle no response", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_remap;
    map_page(9'h021, 9'h002, 1'b1);
    access(2'd0, 1'b0, 16'h00FF, "R10 new page", 1'b0, 2'd0, 16'h017F);
    map_page(9'h020, 9'h005, 1'b0);
    access(2'd0, 1'b0, 16'h0010, "R10 unmapped", 1'b1, 2'd3, 16'h0);
    // write and request in the same cycle: request sees old (invalid) entry
    @(negedge clk);
    pt_we = 1'b1; pt_index = 9'h020; pt_frame = 9'h0AA; pt_valid = 1'b1;
    req_valid = 1'b1; req_seg = 2'd0; req_push = 1'b0; req_offset = 16'h0010;
    @(negedge clk);
    pt_we = 1'b0; req_valid = 1'b0;
    check("R10 same cycle old entry", {14'd0, rsp_valid, rsp_trap, rsp_cause, rsp_paddr},
          {14'd0, 1'b1, 1'b1, 2'd3, 16'h0});
    access(2'd0, 1'b0, 16'h0010, "R10 after write", 1'b0, 2'd0, 16'h5510);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_seg = 2'd0; req_push = 1'b0; req_offset = 16'h0;
    pt_we = 1'b0; pt_index = 9'h0; pt_frame = 9'h0; pt_valid = 1'b0;
    code_base  = 16'h1000; code_limit  = 16'h0100;
    data_base  = 16'h2000; data_limit  = 16'h0040;
    stack_base = 16'h3000; stack_limit = 16'd50;
    repeat (3) @(negedge clk);
    t_reset;
    t_unmapped;
    t_code_data;
    t_carry;
    t_stack;
    t_select;
    t_remap;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule